// File: doc/BRIEF.md
# Skewed Hybrid Conditional Branch Predictor

This block predicts the direction of conditional branches from four small tables: a bimodal table, two tables indexed with global history (G0 and G1) and a chooser table. A lookup presents a branch address and a global-history vector. The registered prediction appears one cycle later. The chooser picks either the bimodal bit or the majority vote of the bimodal, G0 and G1 bits.

An update presents the same address and history together with the resolved direction. In that same cycle the block re-reads the current table state at the update indices and decides which bits to write. It uses a partial policy: when the final prediction was right, components that were wrong are left alone. Each table keeps its direction bits and its hysteresis bits in separate arrays. A hysteresis array may be smaller than its direction array, and then neighbouring direction entries share one hysteresis bit.

Each table forms its index from a hash of the address and its own length of history. The history vector and the branch resolution come from outside.

Top module: `bp_skew_top`

## Requirements
- R1: After reset every direction bit is 0 (not taken) and every hysteresis bit is 0 (weak). A chooser bit of 0 selects the bimodal table, so every lookup after reset predicts not taken, and `pred_valid_o` is low.
- R2: A lookup with `lk_valid_i` high in cycle N sets `pred_valid_o` high and `pred_taken_o` in cycle N+1. `pred_valid_o` is low in a cycle that follows one with no lookup.
- R3: The final prediction is the majority of the bimodal, G0 and G1 direction bits when the chooser bit is 1, and the bimodal bit when the chooser bit is 0.
- R4: Each table's direction index is the address bits from `ADDR_LSB` upward, XOR-folded to the table's index width. This is XORed with the lowest history bits of that table's own length, XOR-folded to the same width and rotated left by the table number (bimodal 0, G0 1, G1 2, chooser 3). The hysteresis index is the low bits of the direction index.
- R5: When the final prediction equals the outcome, no direction bit is written. Each voting table whose bit matched the outcome has its hysteresis set to 1. A voting table whose bit did not match is left unchanged.
- R6: When the final prediction differs from the outcome, each of the three voting tables steps a two-bit counter toward the outcome, as follows:
  - If the direction bit matches the outcome, the hysteresis is set to 1.
  - If the direction bit is wrong and the hysteresis is 1, the hysteresis is cleared.
  - If the direction bit is wrong and the hysteresis is 0, the direction bit flips and the hysteresis stays 0.
  - With no update, nothing is written.
- R7: The chooser is written only when the bimodal bit and the majority differ. It steps by the same counter rule toward 1 if the majority matched the outcome, and toward 0 otherwise.
- R8: Direction entries that share a hysteresis index share one hysteresis bit, so training one entry changes the strength of the other.
- R9: A lookup in the same cycle as an update returns the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Branch address for lookup |
| lk_hist_i | input | HIST_W | Global history for lookup, bit 0 most recent |
| up_valid_i | input | 1 | Update request |
| up_addr_i | input | ADDR_W | Branch address being trained |
| up_hist_i | input | HIST_W | History used when that branch was predicted |
| up_taken_i | input | 1 | Resolved direction, 1 = taken |
| pred_valid_o | output | 1 | Prediction valid, one cycle after lookup |
| pred_taken_o | output | 1 | Predicted direction |

## Verification
The bench uses a reduced configuration and goes after three corner cases.

- **Counter walk on a single entry.** It drives one entry from weak to strong and back. A design that flipped a strong counter, or failed to flip a weak one, predicts the opposite direction one lookup too early or too late.
- **Shared hysteresis bit.** Two addresses alias in the bimodal hysteresis array. After the second address weakens the shared bit, one wrong outcome on the first address must flip its prediction. A design with private hysteresis would keep predicting taken.
- **Exhaustive history sweep.** It runs every 6-bit history over sixteen addresses, against a reference built from the index and training rules. The outcomes make G0 and G1 disagree with the bimodal table, and half the steps issue a lookup and an update together. This exposes a chooser trained in the wrong direction, a component written when it should be left alone, and a lookup that sees its own update.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Table numbering; also used as the per-table history rotation amount.
    localparam int NCOMP = 4;

    typedef enum logic [1:0] {
        C_BIM  = 2'd0,
        C_G0   = 2'd1,
        C_G1   = 2'd2,
        C_META = 2'd3
    } comp_e;

    // State read from one table at one index.
    typedef struct packed {
        logic pred;
        logic hyst;
    } ctr_rd_t;

    // Write request to one table; direction and hysteresis arrays are separate.
    typedef struct packed {
        logic pred_we;
        logic pred_d;
        logic hyst_we;
        logic hyst_d;
    } ctr_wr_t;

    localparam ctr_wr_t CTR_WR_IDLE = '0;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Two-bit counter step toward dir: agree -> strengthen, strong wrong -> weaken,
    // weak wrong -> flip direction (hysteresis stays weak, not written).
    function automatic ctr_wr_t ctr_step(input ctr_rd_t cur, input logic dir);
        ctr_wr_t w;
        w = CTR_WR_IDLE;
        if (cur.pred == dir) begin
            w.hyst_we = 1'b1;
            w.hyst_d  = 1'b1;
        end else if (cur.hyst) begin
            w.hyst_we = 1'b1;
            w.hyst_d  = 1'b0;
        end else begin
            w.pred_we = 1'b1;
            w.pred_d  = dir;
        end
        return w;
    endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int AW  = 30,   // address bits above the ignored low bits
    parameter int HL  = 4,    // history length used by this table
    parameter int PW  = 8,    // log2 of direction array depth
    parameter int HW  = 8,    // log2 of hysteresis array depth, HW <= PW
    parameter int ROT = 0     // history rotation, makes the hashes differ
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [AW-1:0] lk_addr_i,
    input  logic [HL-1:0] lk_hist_i,
    output logic          lk_pred_o,
    input  logic [AW-1:0] up_addr_i,
    input  logic [HL-1:0] up_hist_i,
    output ctr_rd_t       up_rd_o,
    input  ctr_wr_t       up_wr_i
);

    localparam int PDEPTH = 1 << PW;
    localparam int HDEPTH = 1 << HW;
    localparam int RSH    = ROT % PW;

    logic pred_q [PDEPTH];
    logic hyst_q [HDEPTH];

    function automatic logic [PW-1:0] make_idx(input logic [AW-1:0] a,
                                               input logic [HL-1:0] h);
        logic [PW-1:0] fa;
        logic [PW-1:0] fh;
        fa = '0;
        fh = '0;
        for (int i = 0; i < AW; i++) fa[i % PW] = fa[i % PW] ^ a[i];
        for (int i = 0; i < HL; i++) fh[i % PW] = fh[i % PW] ^ h[i];
        fh = (fh << RSH) | (fh >> (PW - RSH));
        return fa ^ fh;
    endfunction

    logic [PW-1:0] lk_pidx;
    logic [PW-1:0] up_pidx;
    logic [HW-1:0] up_hidx;

    assign lk_pidx = make_idx(lk_addr_i, lk_hist_i);
    assign up_pidx = make_idx(up_addr_i, up_hist_i);
    assign up_hidx = up_pidx[HW-1:0];

    assign lk_pred_o    = pred_q[lk_pidx];
    assign up_rd_o.pred = pred_q[up_pidx];
    assign up_rd_o.hyst = hyst_q[up_hidx];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < PDEPTH; i++) pred_q[i] <= 1'b0;
        end else if (up_wr_i.pred_we) begin
            pred_q[up_pidx] <= up_wr_i.pred_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < HDEPTH; i++) hyst_q[i] <= 1'b0;
        end else if (up_wr_i.hyst_we) begin
            hyst_q[up_hidx] <= up_wr_i.hyst_d;
        end
    end

endmodule

// File: rtl/bp_vote.sv
module bp_vote
    import bp_pkg::*;
(
    input  logic bim_i,
    input  logic g0_i,
    input  logic g1_i,
    input  logic meta_i,
    output logic final_o
);

    logic maj;

    assign maj     = majority3(bim_i, g0_i, g1_i);
    assign final_o = meta_i ? maj : bim_i;

endmodule

// File: rtl/bp_train.sv
module bp_train
    import bp_pkg::*;
(
    input  logic                   valid_i,
    input  logic                   taken_i,
    input  ctr_rd_t [NCOMP-1:0]    rd_i,
    output logic                   final_o,
    output ctr_wr_t [NCOMP-1:0]    wr_o
);

    logic maj;
    logic correct;
    logic disagree;

    bp_vote u_vote (
        .bim_i  (rd_i[C_BIM].pred),
        .g0_i   (rd_i[C_G0].pred),
        .g1_i   (rd_i[C_G1].pred),
        .meta_i (rd_i[C_META].pred),
        .final_o(final_o)
    );

    assign maj      = majority3(rd_i[C_BIM].pred, rd_i[C_G0].pred, rd_i[C_G1].pred);
    assign correct  = (final_o == taken_i);
    assign disagree = (rd_i[C_BIM].pred != maj);

    // Voting tables: partial update when the final answer was right.
    for (genvar c = 0; c < 3; c++) begin : g_voter
        always_comb begin
            wr_o[c] = CTR_WR_IDLE;
            if (valid_i && !(correct && rd_i[c].pred != taken_i)) begin
                wr_o[c] = ctr_step(rd_i[c], taken_i);
            end
        end
    end

    // Chooser: trained only when the two candidates differ; 1 means majority.
    always_comb begin
        wr_o[C_META] = CTR_WR_IDLE;
        if (valid_i && disagree) begin
            wr_o[C_META] = ctr_step(rd_i[C_META], maj == taken_i);
        end
    end

endmodule

// File: rtl/bp_skew_top.sv
module bp_skew_top
    import bp_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int ADDR_LSB     = 2,   // at least 1
    parameter int HIST_W       = 21,
    parameter int BIM_PRED_LG  = 8,
    parameter int BIM_HYST_LG  = 8,
    parameter int BIM_HIST_LEN = 4,
    parameter int G0_PRED_LG   = 10,
    parameter int G0_HYST_LG   = 9,
    parameter int G0_HIST_LEN  = 13,
    parameter int G1_PRED_LG   = 10,
    parameter int G1_HYST_LG   = 10,
    parameter int G1_HIST_LEN  = 21,
    parameter int META_PRED_LG = 10,
    parameter int META_HYST_LG = 9,
    parameter int META_HIST_LEN = 17
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    input  logic [HIST_W-1:0] lk_hist_i,
    input  logic              up_valid_i,
    input  logic [ADDR_W-1:0] up_addr_i,
    input  logic [HIST_W-1:0] up_hist_i,
    input  logic              up_taken_i,
    output logic              pred_valid_o,
    output logic              pred_taken_o
);

    localparam int AW = ADDR_W - ADDR_LSB;
    localparam int PRED_LG [NCOMP] = '{BIM_PRED_LG, G0_PRED_LG, G1_PRED_LG, META_PRED_LG};
    localparam int HYST_LG [NCOMP] = '{BIM_HYST_LG, G0_HYST_LG, G1_HYST_LG, META_HYST_LG};
    localparam int HIST_LN [NCOMP] = '{BIM_HIST_LEN, G0_HIST_LEN, G1_HIST_LEN, META_HIST_LEN};

    logic [NCOMP-1:0]    lk_pred;
    ctr_rd_t [NCOMP-1:0] up_rd;
    ctr_wr_t [NCOMP-1:0] up_wr;
    logic                up_final;
    logic                lk_final;
    logic                unused_addr_lsb;

    assign unused_addr_lsb = ^{lk_addr_i[ADDR_LSB-1:0], up_addr_i[ADDR_LSB-1:0]};

    for (genvar c = 0; c < NCOMP; c++) begin : g_tbl
        bp_table #(
            .AW (AW),
            .HL (HIST_LN[c]),
            .PW (PRED_LG[c]),
            .HW (HYST_LG[c]),
            .ROT(c)
        ) u_tbl (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .lk_addr_i(lk_addr_i[ADDR_W-1:ADDR_LSB]),
            .lk_hist_i(lk_hist_i[HIST_LN[c]-1:0]),
            .lk_pred_o(lk_pred[c]),
            .up_addr_i(up_addr_i[ADDR_W-1:ADDR_LSB]),
            .up_hist_i(up_hist_i[HIST_LN[c]-1:0]),
            .up_rd_o  (up_rd[c]),
            .up_wr_i  (up_wr[c])
        );
    end

    bp_vote u_lk_vote (
        .bim_i  (lk_pred[C_BIM]),
        .g0_i   (lk_pred[C_G0]),
        .g1_i   (lk_pred[C_G1]),
        .meta_i (lk_pred[C_META]),
        .final_o(lk_final)
    );

    bp_train u_train (
        .valid_i(up_valid_i),
        .taken_i(up_taken_i),
        .rd_i   (up_rd),
        .final_o(up_final),
        .wr_o   (up_wr)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pred_valid_o <= 1'b0;
            pred_taken_o <= 1'b0;
        end else begin
            pred_valid_o <= lk_valid_i;
            pred_taken_o <= lk_valid_i ? lk_final : 1'b0;
        end
    end

endmodule

// File: rtl/bp_skew_chk.sv
module bp_skew_chk
    import bp_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                lk_valid_i,
    input logic                pred_valid_o,
    input logic                up_valid_i,
    input logic                up_taken_i,
    input logic                up_final,
    input ctr_rd_t [NCOMP-1:0] up_rd,
    input ctr_wr_t [NCOMP-1:0] up_wr
);

    logic vote_maj;
    assign vote_maj = (up_rd[0].pred & up_rd[1].pred) | (up_rd[0].pred & up_rd[2].pred)
                    | (up_rd[1].pred & up_rd[2].pred);

    p_reset_quiet_r1: assert property (@(posedge clk_i) rst_i |=> !pred_valid_o);

    p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        lk_valid_i |=> pred_valid_o);

    p_valid_drops_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !lk_valid_i |=> !pred_valid_o);

    p_correct_no_pred_write_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (up_valid_i && up_final == up_taken_i)
        |-> !(up_wr[0].pred_we || up_wr[1].pred_we || up_wr[2].pred_we));

    for (genvar c = 0; c < 3; c++) begin : g_voter_chk
        p_wrong_untouched_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (up_valid_i && up_final == up_taken_i && up_rd[c].pred != up_taken_i)
            |-> !(up_wr[c].pred_we || up_wr[c].hyst_we));

        p_mispredict_trains_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            (up_valid_i && up_final != up_taken_i)
            |-> (up_wr[c].pred_we || up_wr[c].hyst_we));
    end

    p_idle_no_write_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !up_valid_i |-> $countones({up_wr[0], up_wr[1], up_wr[2], up_wr[3]}) == 0);

    p_meta_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (up_valid_i && up_rd[0].pred == vote_maj)
        |-> !(up_wr[3].pred_we || up_wr[3].hyst_we));

endmodule

bind bp_skew_top bp_skew_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .lk_valid_i  (lk_valid_i),
    .pred_valid_o(pred_valid_o),
    .up_valid_i  (up_valid_i),
    .up_taken_i  (up_taken_i),
    .up_final    (up_final),
    .up_rd       (up_rd),
    .up_wr       (up_wr)
);

// File: tb/bp_skew_top_tb_top.sv
module bp_skew_top_tb_top;

    localparam int ADDR_W = 10;
    localparam int HIST_W = 6;
    localparam int PW [4] = '{4, 5, 5, 5};
    localparam int HW [4] = '{3, 4, 5, 4};
    localparam int HL [4] = '{2, 3, 6, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [HIST_W-1:0] lk_hist = '0;
    logic up_valid = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [HIST_W-1:0] up_hist = '0;
    logic up_taken = 1'b0;
    logic pred_valid;
    logic pred_taken;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int mp [4][32];
    int mh [4][32];

    always #2 clk = ~clk;

    bp_skew_top #(
        .ADDR_W(ADDR_W), .ADDR_LSB(2), .HIST_W(HIST_W),
        .BIM_PRED_LG(4), .BIM_HYST_LG(3), .BIM_HIST_LEN(2),
        .G0_PRED_LG(5),  .G0_HYST_LG(4),  .G0_HIST_LEN(3),
        .G1_PRED_LG(5),  .G1_HYST_LG(5),  .G1_HIST_LEN(6),
        .META_PRED_LG(5), .META_HYST_LG(4), .META_HIST_LEN(4)
    ) dut_i (
        .clk_i(clk), .rst_i(rst),
        .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_hist_i(lk_hist),
        .up_valid_i(up_valid), .up_addr_i(up_addr), .up_hist_i(up_hist),
        .up_taken_i(up_taken),
        .pred_valid_o(pred_valid), .pred_taken_o(pred_taken)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Reference index from R4.
    function automatic int pidx(input int c, input int a, input int h);
        int m, hi, fa, fh, r;
        m  = (1 << PW[c]) - 1;
        hi = a >> 2;
        fa = 0;
        fh = 0;
        for (int i = 0; i < ADDR_W - 2; i++) if ((hi >> i) & 1) fa ^= (1 << (i % PW[c]));
        for (int i = 0; i < HL[c]; i++) if ((h >> i) & 1) fh ^= (1 << (i % PW[c]));
        r  = c % PW[c];
        fh = ((fh << r) | (fh >> (PW[c] - r))) & m;
        return fa ^ fh;
    endfunction

    function automatic int hidx(input int c, input int a, input int h);
        return pidx(c, a, h) & ((1 << HW[c]) - 1);
    endfunction

    function automatic int model_pred(input int a, input int h);
        int b, g0, g1, mt, mj;
        b  = mp[0][pidx(0, a, h)];
        g0 = mp[1][pidx(1, a, h)];
        g1 = mp[2][pidx(2, a, h)];
        mt = mp[3][pidx(3, a, h)];
        mj = (b + g0 + g1) >= 2 ? 1 : 0;
        return mt ? mj : b;
    endfunction

    task automatic model_step(input int c, input int a, input int h, input int dir);
        int pi, hi;
        pi = pidx(c, a, h);
        hi = hidx(c, a, h);
        if (mp[c][pi] == dir) mh[c][hi] = 1;
        else if (mh[c][hi] == 1) mh[c][hi] = 0;
        else mp[c][pi] = dir;
    endtask

    task automatic model_update(input int a, input int h, input int t);
        int p [4];
        int mj, fin;
        for (int c = 0; c < 4; c++) p[c] = mp[c][pidx(c, a, h)];
        mj  = (p[0] + p[1] + p[2]) >= 2 ? 1 : 0;
        fin = p[3] ? mj : p[0];
        for (int c = 0; c < 3; c++) begin
            if (!(fin == t && p[c] != t)) model_step(c, a, h, t);
        end
        if (p[0] != mj) model_step(3, a, h, (mj == t) ? 1 : 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 32; i++) begin
                mp[c][i] = 0;
                mh[c][i] = 0;
            end
    endtask

    task automatic lookup(input int a, input int h, input logic exp, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = ADDR_W'(a); lk_hist = HIST_W'(h);
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, pred_valid, 1'b1);
        chk(req, pred_taken, exp);
    endtask

    task automatic update(input int a, input int h, input int t);
        @(negedge clk);
        up_valid = 1'b1; up_addr = ADDR_W'(a); up_hist = HIST_W'(h); up_taken = t[0];
        @(negedge clk);
        up_valid = 1'b0;
        model_update(a, h, t);
    endtask

    task automatic both(input int a, input int h, input int t, input string req);
        logic e;
        e = model_pred(a, h)[0];
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = ADDR_W'(a); lk_hist = HIST_W'(h);
        up_valid = 1'b1; up_addr = ADDR_W'(a); up_hist = HIST_W'(h); up_taken = t[0];
        @(negedge clk);
        lk_valid = 1'b0; up_valid = 1'b0;
        model_update(a, h, t);
        chk(req, pred_taken, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state, no prediction pending, everything not taken.
        chk("R1 valid low", pred_valid, 1'b0);
        for (int a = 0; a < 16; a++) lookup(a << 2, (a * 5) & 63, 1'b0, "R1 reset predicts not taken");
        // R2: valid drops in the cycle after an idle one.
        @(negedge clk);
        chk("R2 valid drops", pred_valid, 1'b0);

        // R8: 0x00 and 0x20 share bimodal hysteresis index 0 (direction idx 0 and 8).
        update(32'h00, 0, 1);
        update(32'h00, 0, 1);
        update(32'h20, 0, 1);
        lookup(32'h20, 0, 1'b0, "R8 shared strong bit only weakened");
        lookup(32'h00, 0, 1'b1, "R8 first entry still taken");
        update(32'h00, 0, 0);
        lookup(32'h00, 0, 1'b0, "R8 weakened shared bit lets entry flip");

        // R6/R5: counter walk on one entry (address 0x1C, history 0).
        update(32'h1C, 0, 1);
        lookup(32'h1C, 0, 1'b1, "R6 weak entry flips to taken");
        update(32'h1C, 0, 0);
        lookup(32'h1C, 0, 1'b0, "R6 weak entry flips back");
        update(32'h1C, 0, 1);
        update(32'h1C, 0, 1);
        update(32'h1C, 0, 0);
        lookup(32'h1C, 0, 1'b1, "R5 R6 strong entry survives one miss");
        update(32'h1C, 0, 0);
        lookup(32'h1C, 0, 1'b0, "R6 second miss flips");

        // R9: lookup and update together see the old state.
        both(32'h1C, 0, 1, "R9 same-cycle lookup sees old state");
        lookup(32'h1C, 0, 1'b1, "R9 update visible afterwards");

        // Sweep: all histories over sixteen addresses, against the R3..R7 reference.
        do_reset();
        for (int rnd = 0; rnd < 4; rnd++)
            for (int a = 0; a < 16; a++)
                for (int h = 0; h < 64; h++) begin
                    int addr, t;
                    addr = ((a * 37) & 255) << 2;
                    t = (a >= 12) ? (a & 1) : (((h ^ (h >> 2)) & 1) ^ ((a >> 1) & 1));
                    if (h[0]) begin
                        both(addr, h, t, "R3 R4 R5 R6 R7 R9 sweep combined");
                    end else begin
                        lookup(addr, h, model_pred(addr, h)[0], "R3 R4 R5 R6 R7 sweep lookup");
                        update(addr, h, t);
                    end
                end
        finish_run();
    end

endmodule